// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block sits beside the decode stage of a five-stage in-order pipeline. It handles the one data dependency that forwarding cannot cover. The case is a load in the execute stage whose data has not yet come back from memory, while the instruction just behind it in decode reads the register that the load will write. For that case the block holds the program counter and the fetch/decode pipeline register for one clock. It also replaces the control word about to enter the decode/execute register with all zeros. The zero word sends a slot down the pipe that writes neither memory nor registers.

The next cycle the load has moved on to the memory stage and a bubble occupies execute. The hazard condition is therefore gone, and the held instruction proceeds, taking the loaded value from the forwarding network. One such dependency costs exactly one bubble. All outputs are combinational functions of the current pipeline-register contents, so the freeze acts at the next clock edge.

Top module: `load_use_stall`

## Requirements
- R1: When `ex_mem_rd` is 1, `ex_dst` is non-zero and `ex_dst` equals `id_src_a`, the unit signals a stall.
- R2: When `ex_mem_rd` is 1, `ex_dst` is non-zero and `ex_dst` equals `id_src_b`, the unit signals a stall.
- R3: During a stall, `pc_we` and `ifid_we` are both 0, so the PC and the fetch/decode register keep their contents.
- R4: During a stall, `ctrl_zero_sel` is 1 and `ex_ctrl` is all zeros, turning the slot into a bubble.
- R5: Without a stall, `pc_we` and `ifid_we` are 1, `ctrl_zero_sel` is 0, and `ex_ctrl` equals `id_ctrl`.
- R6: A load whose destination register index is 0 never causes a stall, whatever the decode sources are.
- R7: An instruction in execute with `ex_mem_rd` at 0 never causes a stall, even when its `ex_dst` matches a decode source.
- R8: The outputs follow the inputs within the same cycle, with no clock edge in between.
- R9: In a running pipeline, each load-then-use pair stalls for exactly one cycle, and instructions without such a dependency never stall. This includes a load that depends on a load directly ahead of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_mem_rd | input | 1 | Memory-read bit of the instruction held in the decode/execute register |
| ex_dst | input | REG_AW | Rt field (load destination) of the instruction in the decode/execute register |
| id_src_a | input | REG_AW | First source register field (Rs) of the instruction in decode |
| id_src_b | input | REG_AW | Second source register field (Rt) of the instruction in decode |
| id_ctrl | input | CTRL_W | Control word produced by the main decoder |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode pipeline register write enable |
| ctrl_zero_sel | output | 1 | Selects the all-zero control word for the decode/execute register |
| ex_ctrl | output | CTRL_W | Control word to load into the decode/execute register |

## Verification
The bench uses the default parameters: 5-bit register indices, a 9-bit control word and register 0 exempt from matching. With these values the zero-register exemption and a full-width control word are both reachable. A behavioural model of the fetch/decode and decode/execute registers runs a 16-instruction program. The program covers a dependency on the first source and on the second source, a load to register 0, a non-load producer, and back-to-back loads. The bench compares every output each cycle and then counts the stall cycles charged to each instruction.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    // Which control word enters the decode/execute register.
    typedef enum logic {
        SLOT_PASS   = 1'b0,
        SLOT_BUBBLE = 1'b1
    } slot_sel_e;

    // Enables handed back to fetch and decode.
    typedef struct packed {
        logic      pc_we;
        logic      ifid_we;
        slot_sel_e slot;
    } stall_ctl_t;

    function automatic stall_ctl_t make_ctl(input logic stall);
        stall_ctl_t c;
        c.pc_we   = ~stall;
        c.ifid_we = ~stall;
        c.slot    = stall ? SLOT_BUBBLE : SLOT_PASS;
        return c;
    endfunction

endpackage

// File: rtl/hzd_src_cmp.sv
module hzd_src_cmp #(
    parameter int REG_AW      = 5,
    parameter bit ZERO_EXEMPT = 1'b1
) (
    input  logic              load_in_ex,
    input  logic [REG_AW-1:0] dst,
    input  logic [REG_AW-1:0] src,
    output logic              hit
);

    logic same_reg;
    assign same_reg = (dst == src);

    generate
        if (ZERO_EXEMPT) begin : g_exempt
            logic dst_live;
            assign dst_live = |dst;
            assign hit = load_in_ex & dst_live & same_reg;
        end else begin : g_plain
            assign hit = load_in_ex & same_reg;
        end
    endgenerate

endmodule

// File: rtl/hzd_bubble_mux.sv
module hzd_bubble_mux
    import hzd_pkg::*;
#(
    parameter int CTRL_W = 9
) (
    input  slot_sel_e         slot,
    input  logic [CTRL_W-1:0] ctrl_in,
    output logic [CTRL_W-1:0] ctrl_out
);

    always_comb begin
        unique case (slot)
            SLOT_BUBBLE: ctrl_out = '0;
            default:     ctrl_out = ctrl_in;
        endcase
    end

endmodule

// File: rtl/load_use_stall.sv
module load_use_stall
    import hzd_pkg::*;
#(
    parameter int REG_AW      = 5,
    parameter int CTRL_W      = 9,
    parameter bit ZERO_EXEMPT = 1'b1
) (
    input  logic              ex_mem_rd,
    input  logic [REG_AW-1:0] ex_dst,
    input  logic [REG_AW-1:0] id_src_a,
    input  logic [REG_AW-1:0] id_src_b,
    input  logic [CTRL_W-1:0] id_ctrl,
    output logic              pc_we,
    output logic              ifid_we,
    output logic              ctrl_zero_sel,
    output logic [CTRL_W-1:0] ex_ctrl
);

    localparam int NUM_SRC = 2;

    logic [REG_AW-1:0]  srcs [NUM_SRC];
    logic [NUM_SRC-1:0] hits;
    logic               stall;
    stall_ctl_t         ctl;

    assign srcs[0] = id_src_a;
    assign srcs[1] = id_src_b;

    // One comparator per decode source operand.
    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            hzd_src_cmp #(
                .REG_AW      (REG_AW),
                .ZERO_EXEMPT (ZERO_EXEMPT)
            ) u_cmp (
                .load_in_ex (ex_mem_rd),
                .dst        (ex_dst),
                .src        (srcs[g]),
                .hit        (hits[g])
            );
        end
    endgenerate

    assign stall = |hits;
    assign ctl   = make_ctl(stall);

    hzd_bubble_mux #(
        .CTRL_W (CTRL_W)
    ) u_mux (
        .slot     (ctl.slot),
        .ctrl_in  (id_ctrl),
        .ctrl_out (ex_ctrl)
    );

    assign pc_we         = ctl.pc_we;
    assign ifid_we       = ctl.ifid_we;
    assign ctrl_zero_sel = (ctl.slot == SLOT_BUBBLE);

    always_comb begin
        AST_HOLD_PAIRED: assert (pc_we == ifid_we) else $error("pc and ifid enables differ"); // R3
        AST_BUBBLE_ZERO: assert (!ctrl_zero_sel || ex_ctrl == '0) else $error("bubble carries control"); // R4
        AST_PASS_THROUGH: assert (ctrl_zero_sel || ex_ctrl == id_ctrl) else $error("control altered"); // R5
        AST_NOLOAD_FREE: assert (ex_mem_rd || pc_we) else $error("stall without load"); // R7
        AST_SEL_VS_HOLD: assert (ctrl_zero_sel == !pc_we) else $error("select and hold disagree"); // R4
        if (ZERO_EXEMPT) begin
            AST_ZERO_DST: assert (ex_dst != '0 || pc_we) else $error("stall on register zero"); // R6
        end
    end

endmodule

// File: tb/load_use_stall_tb.sv
module load_use_stall_tb;

    localparam int CLK_PERIOD = 10;
    localparam int REG_AW     = 5;
    localparam int CTRL_W     = 9;
    localparam int NPROG      = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;

    logic              ex_mem_rd = 1'b0;
    logic [REG_AW-1:0] ex_dst    = '0;
    logic [REG_AW-1:0] id_src_a  = '0;
    logic [REG_AW-1:0] id_src_b  = '0;
    logic [CTRL_W-1:0] id_ctrl   = '0;
    logic              pc_we;
    logic              ifid_we;
    logic              ctrl_zero_sel;
    logic [CTRL_W-1:0] ex_ctrl;

    load_use_stall #(
        .REG_AW      (REG_AW),
        .CTRL_W      (CTRL_W),
        .ZERO_EXEMPT (1'b1)
    ) u_dut (
        .ex_mem_rd     (ex_mem_rd),
        .ex_dst        (ex_dst),
        .id_src_a      (id_src_a),
        .id_src_b      (id_src_b),
        .id_ctrl       (id_ctrl),
        .pc_we         (pc_we),
        .ifid_we       (ifid_we),
        .ctrl_zero_sel (ctrl_zero_sel),
        .ex_ctrl       (ex_ctrl)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Program: is-load flag, Rs field, Rt field (Rt is the load destination).
    bit isld  [NPROG];
    int fa    [NPROG];
    int fb    [NPROG];
    int exp_stalls [NPROG];
    int got_stalls [NPROG];

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic setp(input int i, input bit l, input int a, input int b, input int e);
        isld[i] = l; fa[i] = a; fb[i] = b; exp_stalls[i] = e; got_stalls[i] = 0;
    endtask

    function automatic int ctrl_of(input int i);
        return 256 + i + 1;
    endfunction

    initial begin
        int ifid_i;
        int idex_i;
        int pc;
        bit exp_stall;
        bit ma;
        bit mb;
        string tag;

        setp(0,  1, 1, 2, 0);   // load r2
        setp(1,  0, 2, 5, 1);   // uses r2 as Rs -> one stall
        setp(2,  0, 6, 2, 0);
        setp(3,  0, 4, 2, 0);
        setp(4,  0, 6, 7, 0);
        setp(5,  1, 3, 0, 0);   // load to r0
        setp(6,  0, 0, 0, 0);   // reads r0: no stall
        setp(7,  1, 1, 7, 0);   // load r7
        setp(8,  0, 5, 7, 1);   // uses r7 as Rt -> one stall
        setp(9,  0, 4, 5, 0);   // non-load, Rt r5
        setp(10, 0, 5, 5, 0);   // reads r5: no stall
        setp(11, 1, 2, 1, 0);   // load r1
        setp(12, 1, 1, 9, 1);   // load using r1 -> stall
        setp(13, 0, 9, 9, 1);   // uses r9 on both -> stall
        setp(14, 1, 4, 3, 0);   // load r3
        setp(15, 0, 6, 8, 0);   // unrelated

        ifid_i = -1; idex_i = -1; pc = 0;
        repeat (2) @(posedge clk);
        rst = 1'b0;

        // Reset state: empty pipeline registers.
        @(negedge clk);
        chk("R5", "reset pc_we", int'(pc_we), 1);
        chk("R5", "reset ifid_we", int'(ifid_we), 1);
        chk("R5", "reset ctrl_zero_sel", int'(ctrl_zero_sel), 0);

        while (!(pc >= NPROG && ifid_i < 0 && idex_i < 0)) begin
            @(posedge clk);
            #1;
            ex_mem_rd = (idex_i >= 0) ? isld[idex_i] : 1'b0;
            ex_dst    = (idex_i >= 0) ? REG_AW'(fb[idex_i]) : '0;
            id_src_a  = (ifid_i >= 0) ? REG_AW'(fa[ifid_i]) : '0;
            id_src_b  = (ifid_i >= 0) ? REG_AW'(fb[ifid_i]) : '0;
            id_ctrl   = (ifid_i >= 0) ? CTRL_W'(ctrl_of(ifid_i)) : '0;

            ma = (idex_i >= 0) && (ifid_i >= 0) && (fb[idex_i] == fa[ifid_i]);
            mb = (idex_i >= 0) && (ifid_i >= 0) && (fb[idex_i] == fb[ifid_i]);
            exp_stall = (idex_i >= 0) && isld[idex_i] && (fb[idex_i] != 0) && (ma || mb);

            if (exp_stall)                                tag = ma ? "R1" : "R2";
            else if (idex_i >= 0 && isld[idex_i] && fb[idex_i] == 0) tag = "R6";
            else if (idex_i >= 0 && !isld[idex_i] && (ma || mb))     tag = "R7";
            else                                          tag = "R5";

            @(negedge clk);
            chk(tag, "ctrl_zero_sel", int'(ctrl_zero_sel), int'(exp_stall));
            chk(exp_stall ? "R3" : "R5", "pc_we", int'(pc_we), int'(!exp_stall));
            chk(exp_stall ? "R3" : "R5", "ifid_we", int'(ifid_we), int'(!exp_stall));
            chk(exp_stall ? "R4" : "R5", "ex_ctrl", int'(ex_ctrl),
                exp_stall ? 0 : int'(id_ctrl));

            // Advance the model pipeline from the expected decision.
            if (exp_stall) begin
                got_stalls[ifid_i]++;
                idex_i = -1;
            end else begin
                idex_i = ifid_i;
                ifid_i = (pc < NPROG) ? pc : -1;
                pc++;
            end
        end

        for (int i = 0; i < NPROG; i++)
            chk("R9", $sformatf("stall cycles of instr %0d", i), got_stalls[i], exp_stalls[i]);

        // R8: response without any clock edge.
        @(negedge clk);
        ex_mem_rd = 1'b1; ex_dst = 5'd12; id_src_a = 5'd12; id_src_b = 5'd3; id_ctrl = 9'h1AB;
        #1;
        chk("R8", "pc_we same cycle", int'(pc_we), 0);
        chk("R8", "ex_ctrl same cycle", int'(ex_ctrl), 0);
        id_src_a = 5'd13;
        #1;
        chk("R8", "pc_we release", int'(pc_we), 1);
        chk("R8", "ex_ctrl release", int'(ex_ctrl), 'h1AB);
        ex_dst = 5'd0; id_src_a = 5'd0; id_src_b = 5'd0;
        #1;
        chk("R6", "zero dst with zero sources", int'(ctrl_zero_sel), 0);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule